// File: doc/BRIEF.md
# Fresh-Data Result Register

This block holds the latest result of a co-processor and presents it to a faster host as one polled word. The co-processor marks each new result with a strobe. The block captures the result on the strobe's rising edge and sets a freshness flag in the top bit of the word. The host polls the word at any time and can tell whether the result is new or has already been read by checking that one bit.

The host signals a read on a request line that is asynchronous to the block's clock. The block synchronises this line and turns each rising edge into one internal pulse. The pulse arms a pending bit, and the flag is cleared on the following cycle. The flag therefore stays set while the host completes its read. If a new result arrives in the same cycle as a clear, the new result keeps its flag. The bits between the result field and the flag always read as zero.

Top module: `fresh_word_reg`

## Requirements
- R1: When the strobe is high at a clock edge and was low at the previous edge, the result input is stored in word bits 24..0 and bit 31 becomes 1. Both are visible after that edge.
- R2: Word bits 30..25 always read 0, whatever the result input is.
- R3: Only a rising strobe edge captures. While the strobe stays high, or stays low, bits 24..0 keep their value even if the result input changes.
- R4: With the default two-stage synchroniser, a read request that rises between clock edges clears bit 31 at the fourth clock edge after the rise. Bit 31 is still 1 after the third edge.
- R5: A read request that stays high for any length of time produces exactly one clear. A result captured while the request is still held stays fresh until the request falls and rises again.
- R6: If a capture and a pending clear fall on the same clock edge, the capture wins and bit 31 stays 1.
- R7: A read request changes bit 31 only. Bits 30..0 are unchanged by it.
- R8: Synchronous reset drives the word to 0 and clears the pending bit and all edge-detection history. A strobe that is already high at the first edge after reset is therefore taken as a rising edge and captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| res_valid_i | input | 1 | New-result strobe; its rising edge captures |
| res_data_i | input | RES_W (25) | Result value from the co-processor |
| rd_req_i | input | 1 | Host read request, asynchronous |
| word_o | output | WORD_W (32) | Polled word: flag, zero padding, result |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 25-bit result and a two-stage synchroniser. The six padding bits are therefore present, so the zero-fill can be observed, and the fixed synchroniser depth gives an exact clear latency of four edges. That latency makes it possible to line a capture up on the very edge where a clear lands, which is the collision case. The same settings let the bench hold a request high across a capture to show that a held request does not clear twice.

// File: rtl/fresh_word_pkg.sv
package fresh_word_pkg;
   localparam int unsigned DEF_WORD_W      = 32;
   localparam int unsigned DEF_RES_W       = 25;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // number of zero bits between result field and flag
   function automatic int unsigned pad_width(input int unsigned word_w,
                                             input int unsigned res_w);
      return word_w - 1 - res_w;
   endfunction
endpackage

// File: rtl/fwr_edge_det.sv
module fwr_edge_det (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic rise_o
);
   logic hist_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) hist_q <= 1'b0;
      else       hist_q <= level_i;
   end

   assign rise_o = level_i & ~hist_q;
endmodule

// File: rtl/fwr_req_sync.sv
module fwr_req_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic pulse_o
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fwr_req_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q[0] <= 1'b0;
      else       chain_q[0] <= async_i;
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk_i) begin
            if (rst_i) chain_q[g] <= 1'b0;
            else       chain_q[g] <= chain_q[g-1];
         end
      end
   endgenerate

   fwr_edge_det u_rise (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (chain_q[LAST]),
      .rise_o  (pulse_o)
   );
endmodule

// File: rtl/fwr_word_store.sv
module fwr_word_store #(
   parameter int unsigned WORD_W = fresh_word_pkg::DEF_WORD_W,
   parameter int unsigned RES_W  = fresh_word_pkg::DEF_RES_W
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cap_i,
   input  logic              clr_req_i,
   input  logic [RES_W-1:0]  result_i,
   output logic [WORD_W-1:0] word_o,
   output logic              pend_o
);
   localparam int unsigned PAD_W = fresh_word_pkg::pad_width(WORD_W, RES_W);

   logic [RES_W-1:0] res_q;
   logic             flag_q;
   logic             pend_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_q  <= '0;
         flag_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (cap_i) res_q <= result_i;
         // arm on request; a set pending bit is consumed this cycle
         if (clr_req_i) pend_q <= 1'b1;
         if (pend_q)    pend_q <= 1'b0;
         // capture has priority over the delayed clear
         if (cap_i)       flag_q <= 1'b1;
         else if (pend_q) flag_q <= 1'b0;
      end
   end

   generate
      if (PAD_W > 0) begin : g_padded
         assign word_o = {flag_q, {PAD_W{1'b0}}, res_q};
      end else begin : g_packed
         assign word_o = {flag_q, res_q};
      end
   endgenerate

   assign pend_o = pend_q;
endmodule

// File: rtl/fresh_word_reg.sv
module fresh_word_reg #(
   parameter int unsigned WORD_W      = fresh_word_pkg::DEF_WORD_W,
   parameter int unsigned RES_W       = fresh_word_pkg::DEF_RES_W,
   parameter int unsigned SYNC_STAGES = fresh_word_pkg::DEF_SYNC_STAGES
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              res_valid_i,
   input  logic [RES_W-1:0]  res_data_i,
   input  logic              rd_req_i,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (RES_W < 1 || RES_W > WORD_W - 1) begin : g_bad_width
         $error("fresh_word_reg: RES_W must be in 1..WORD_W-1");
      end
   endgenerate

   logic cap_w;
   logic rd_pulse_w;
   logic pend_w;

   fwr_edge_det u_strobe_edge (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (res_valid_i),
      .rise_o  (cap_w)
   );

   fwr_req_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .async_i (rd_req_i),
      .pulse_o (rd_pulse_w)
   );

   fwr_word_store #(.WORD_W(WORD_W), .RES_W(RES_W)) u_store (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .cap_i     (cap_w),
      .clr_req_i (rd_pulse_w),
      .result_i  (res_data_i),
      .word_o    (word_o),
      .pend_o    (pend_w)
   );
endmodule

// File: rtl/fresh_word_chk.sv
module fresh_word_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned RES_W  = 25
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              strobe_i,
   input logic [RES_W-1:0]  res_i,
   input logic [WORD_W-1:0] word_i,
   input logic              pend_i
);
   localparam int unsigned FLAG = WORD_W - 1;

   logic strb_seen_q;
   logic cap_c;

   always_ff @(posedge clk_i) begin
      if (rst_i) strb_seen_q <= 1'b0;
      else       strb_seen_q <= strobe_i;
   end
   assign cap_c = strobe_i & ~strb_seen_q;

   AST_CAPTURE_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
      cap_c |=> (word_i[FLAG] && word_i[RES_W-1:0] == $past(res_i))); // R1

   generate
      if (WORD_W - 1 > RES_W) begin : g_pad_chk
         AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
            word_i[WORD_W-2:RES_W] == '0); // R2
      end
   endgenerate

   AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
      !cap_c |=> $stable(word_i[RES_W-1:0])); // R3

   AST_FLAG_RISE_ON_CAP: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(word_i[FLAG]) |-> $past(cap_c)); // R1

   AST_FLAG_FALL_AFTER_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(word_i[FLAG]) |-> ($past(pend_i) && !$past(cap_c))); // R4

   AST_PEND_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      pend_i |=> !pend_i); // R5

   AST_CAPTURE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
      (cap_c && pend_i) |=> word_i[FLAG]); // R6

   AST_RESET_CLEARS: assert property (@(posedge clk_i)
      rst_i |=> (word_i == '0 && !pend_i)); // R8
endmodule

bind fresh_word_reg fresh_word_chk #(.WORD_W(WORD_W), .RES_W(RES_W)) chk_i (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .strobe_i (res_valid_i),
   .res_i    (res_data_i),
   .word_i   (word_o),
   .pend_i   (pend_w)
);

// File: tb/fresh_word_reg_tb_top.sv
`timescale 1ns/1ps
module fresh_word_reg_tb_top;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned RES_W  = 25;
   localparam int unsigned SYNC   = 2;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              strobe = 1'b0;
   logic [RES_W-1:0]  rdata = '0;
   logic              rd_req = 1'b0;
   logic [WORD_W-1:0] word;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   int          q_cyc[$];
   logic [31:0] q_word[$];
   string       q_tag[$];

   fresh_word_reg #(.WORD_W(WORD_W), .RES_W(RES_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk_i       (clk),
      .rst_i       (rst),
      .res_valid_i (strobe),
      .res_data_i  (rdata),
      .rd_req_i    (rd_req),
      .word_o      (word)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mk(input logic flag, input logic [RES_W-1:0] d);
      return {flag, 6'b0, d};
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic expect_at(input int c, input logic [31:0] w, input string tag);
      q_cyc.push_back(c);
      q_word.push_back(w);
      q_tag.push_back(tag);
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: compare scoreboard items in the cycle they are due
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            if (q_cyc[0] < cyc) begin
               total++;
               bad++;
               $display("FAIL %s: actual=missed expected=%h", q_tag[0], q_word[0]);
            end else begin
               check(word, q_word[0], q_tag[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_word.pop_front());
            void'(q_tag.pop_front());
         end
      end
   end

   task automatic capture(input logic [RES_W-1:0] d, input string tag);
      @(negedge clk);
      strobe = 1'b1;
      rdata  = d;
      expect_at(cyc + 1, mk(1'b1, d), tag);
      @(negedge clk);
      strobe = 1'b0;
      rdata  = ~d;
   endtask

   initial begin
      int c;
      wait_cyc(3);
      check(word, 32'h0, "R8 word zero in reset");
      rst = 1'b0;
      wait_cyc(2);
      check(word, 32'h0, "R8 word zero after reset");

      capture(25'h0123456, "R1 capture");
      wait_cyc(2);
      capture(25'h1FFFFFF, "R2 padding zero with all-ones result");
      wait_cyc(2);

      // R3: strobe held high, data changes, no recapture
      @(negedge clk);
      strobe = 1'b1;
      rdata  = 25'h0ABCDEF;
      expect_at(cyc + 1, mk(1'b1, 25'h0ABCDEF), "R3 first edge captures");
      @(negedge clk);
      rdata = 25'h1555555;
      expect_at(cyc + 1, mk(1'b1, 25'h0ABCDEF), "R3 held strobe no recapture");
      @(negedge clk);
      rdata = 25'h0F0F0F0;
      expect_at(cyc + 1, mk(1'b1, 25'h0ABCDEF), "R3 held strobe no recapture");
      @(negedge clk);
      strobe = 1'b0;
      expect_at(cyc + 2, mk(1'b1, 25'h0ABCDEF), "R3 low strobe no capture");
      wait_cyc(3);

      // R4 / R7: clear latency and only bit 31 changes
      @(negedge clk);
      rd_req = 1'b1;
      c = cyc;
      expect_at(c + 3, mk(1'b1, 25'h0ABCDEF), "R4 flag still set after third edge");
      expect_at(c + 4, mk(1'b0, 25'h0ABCDEF), "R4 R7 flag cleared at fourth edge, data kept");
      wait_cyc(6);

      // R5: request still held; new capture must stay fresh
      capture(25'h0777777, "R5 capture while request held");
      wait_cyc(5);
      check(word, mk(1'b1, 25'h0777777), "R5 held request does not clear again");
      @(negedge clk);
      rd_req = 1'b0;
      wait_cyc(5);
      check(word, mk(1'b1, 25'h0777777), "R5 falling request does not clear");

      // R6: capture on the same edge as the delayed clear
      @(negedge clk);
      rd_req = 1'b1;
      c = cyc;
      wait_cyc(3);
      strobe = 1'b1;
      rdata  = 25'h0246802;
      expect_at(c + 4, mk(1'b1, 25'h0246802), "R6 capture wins over clear");
      @(negedge clk);
      strobe = 1'b0;
      expect_at(c + 6, mk(1'b1, 25'h0246802), "R6 no late clear after collision");
      wait_cyc(4);
      rd_req = 1'b0;
      wait_cyc(4);

      // R7 again: pure clear from a fresh request
      @(negedge clk);
      rd_req = 1'b1;
      c = cyc;
      expect_at(c + 4, mk(1'b0, 25'h0246802), "R7 request touches only bit 31");
      wait_cyc(6);
      rd_req = 1'b0;

      // R8: reset mid-run with strobe high; first edge after reset captures
      @(negedge clk);
      rst    = 1'b1;
      strobe = 1'b1;
      rdata  = 25'h1234567;
      wait_cyc(3);
      check(word, 32'h0, "R8 reset clears word");
      rst = 1'b0;
      expect_at(cyc + 1, mk(1'b1, 25'h1234567), "R8 high strobe after reset captures");
      wait_cyc(2);
      strobe = 1'b0;
      wait_cyc(3);

      if (q_cyc.size() != 0) begin
         total++;
         bad++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", q_cyc.size());
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule